// File: doc/BRIEF.md
# Critical Interrupt Entry Controller

This block handles how a small processor core enters and leaves its highest-priority asynchronous interrupt class. It watches two level-sensitive request sources: an external critical request line and the first time-out request of a watchdog. A single critical-enable bit in the machine state register (MSR) gates both sources. When neither source can be accepted, a request stays pending.

While the pipeline reports an outstanding synchronous precise exception, the block waits. When it accepts a request, it does four things in one clock edge:

- copies the address of the next instruction into a dedicated save register for the resume address;
- copies the whole MSR into a second dedicated save register;
- clears the critical-enable and debug-enable bits in the MSR;
- redirects fetch to a vector. The upper half of the vector comes from a prefix input. The lower half is a fixed per-source offset: 0x0100 for the request line and a separate parameter for the watchdog.

A return-from-critical strobe reverses the entry in one cycle. It restores the MSR from the saved copy and redirects fetch to the saved address. Software re-arms acceptance by writing the MSR with the critical-enable bit set.

Top module: `crit_entry_ctrl`

Default bit positions: critical-enable is MSR bit 14 and debug-enable is MSR bit 9. Bit 0 is the least significant bit.

## Requirements
- R1: While rst_n is low, msr_o, save_pc_o, save_msr_o, take_o, redirect_o and redirect_pc_o are all zero.
- R2: When crit_req_i is high, msr_o bit 14 is 1 and sync_exc_pend_i is low at a clock edge, then after that edge take_o and redirect_o are 1 and redirect_pc_o equals {vec_prefix_i, 16'h0100}.
- R3: While msr_o bit 14 is 0, neither request source causes an entry. A request that is still held is accepted once the bit becomes 1.
- R4: With no entry and no return at an edge, msr_wr_en_i high loads msr_wr_data_i into msr_o after that edge. Writing bit 14 as 1 re-arms acceptance.
- R5: While sync_exc_pend_i is high, no entry occurs. A held request is taken at the first edge where sync_exc_pend_i is low.
- R6: On entry, save_pc_o takes the pc_next_i value and save_msr_o takes the msr_o value, both as present at the accepting edge.
- R7: On entry, msr_o bits 14 and 9 become 0 and every other MSR bit keeps its previous value.
- R8: An accepted watchdog request (wdt_req_i high, crit_req_i low) redirects to {vec_prefix_i, WDT_OFS}, where WDT_OFS defaults to 16'h0200. It is gated by bit 14 exactly like the request line.
- R9: When both sources are accepted in the same cycle, the request line wins and the vector uses offset 16'h0100.
- R10: With rfci_i high and no entry at an edge, after that edge msr_o equals the previous save_msr_o, redirect_o is 1, take_o is 0 and redirect_pc_o equals save_pc_o.
- R11: take_o and redirect_o are single-cycle pulses. A request held high after entry does not cause a second entry while bit 14 stays 0. redirect_pc_o holds its value between redirects.
- R12: At a single edge, entry takes priority over return and over an MSR write, and a return takes priority over an MSR write. A lower-priority input that loses at that edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crit_req_i | input | 1 | Critical request line, level |
| wdt_req_i | input | 1 | Watchdog first time-out request, level |
| sync_exc_pend_i | input | 1 | A synchronous precise exception is outstanding |
| pc_next_i | input | AW | Address of the next instruction to execute |
| vec_prefix_i | input | AW-16 | Upper part of the interrupt vector |
| msr_wr_en_i | input | 1 | Software MSR write strobe |
| msr_wr_data_i | input | MW | MSR write value |
| rfci_i | input | 1 | Return-from-critical strobe |
| take_o | output | 1 | One-cycle pulse: critical entry taken |
| redirect_o | output | 1 | One-cycle pulse: fetch must redirect |
| redirect_pc_o | output | AW | Redirect target address |
| msr_o | output | MW | Current machine state register |
| save_pc_o | output | AW | Saved resume address |
| save_msr_o | output | MW | Saved MSR copy |

## Verification
Every result is registered. A decision made from the inputs and state present at one rising edge appears on all outputs exactly one cycle later, and nothing is visible in the same cycle.

The bench drives inputs at the falling edge and advances its behavioural model at the rising edge. Half a cycle later it compares all six outputs with the model. Because of this, a held request, a sync-pending hold or a same-edge conflict is judged at precisely the cycle its outcome is due.

// File: rtl/crit_pkg.sv
// Package: shared event encoding for the critical interrupt entry block.
// Assumes: one event is chosen per cycle; encoding is local to the block.
package crit_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CRIT = 2'd1,
        EV_WDT  = 2'd2,
        EV_RET  = 2'd3
    } crit_ev_e;
endpackage

// File: rtl/crit_arbiter.sv
// Module: picks this cycle's event and forms the redirect target.
// Assumes: requests are levels; the enable and sync-pending gates apply to
// both sources; the request line outranks the watchdog; entry outranks return.
module crit_arbiter
    import crit_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [15:0] CRIT_OFS = 16'h0100,
    parameter logic [15:0] WDT_OFS  = 16'h0200,
    localparam int         PW       = AW - 16
) (
    input  logic          crit_req_i,
    input  logic          wdt_req_i,
    input  logic          sync_exc_pend_i,
    input  logic          ce_i,
    input  logic          rfci_i,
    input  logic [PW-1:0] vec_prefix_i,
    input  logic [AW-1:0] save_pc_i,
    output crit_ev_e      ev_o,
    output logic [AW-1:0] target_o
);
    logic accept;

    // Gate both sources with the enable bit and the precise-exception hold.
    always_comb accept = ce_i && !sync_exc_pend_i;

    // Choose the event by fixed priority and build its target address.
    always_comb begin
        ev_o     = EV_NONE;
        target_o = save_pc_i;
        if (accept && crit_req_i) begin
            ev_o     = EV_CRIT;
            target_o = {vec_prefix_i, CRIT_OFS};
        end else if (accept && wdt_req_i) begin
            ev_o     = EV_WDT;
            target_o = {vec_prefix_i, WDT_OFS};
        end else if (rfci_i) begin
            ev_o     = EV_RET;
            target_o = save_pc_i;
        end
    end
endmodule

// File: rtl/crit_save_regs.sv
// Module: the save register pair dedicated to critical entry.
// Assumes: loaded only on an entry event; reset clears both.
module crit_save_regs #(
    parameter int AW = 32,
    parameter int MW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] pc_i,
    input  logic [MW-1:0] msr_i,
    output logic [AW-1:0] save_pc_o,
    output logic [MW-1:0] save_msr_o
);
    // Capture the resume address and the machine state on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_pc_o  <= '0;
            save_msr_o <= '0;
        end else if (load_i) begin
            save_pc_o  <= pc_i;
            save_msr_o <= msr_i;
        end
    end
endmodule

// File: rtl/crit_msr_reg.sv
// Module: the machine state register and its update by priority.
// Assumes: entry clears only the two named enables; return restores the saved
// copy; a software write applies only when neither event occurs.
module crit_msr_reg
    import crit_pkg::*;
#(
    parameter int MW     = 32,
    parameter int CE_BIT = 14,
    parameter int DE_BIT = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  crit_ev_e      ev_i,
    input  logic          wr_en_i,
    input  logic [MW-1:0] wr_data_i,
    input  logic [MW-1:0] save_msr_i,
    output logic [MW-1:0] msr_o
);
    localparam logic [MW-1:0] CLR_MASK = ~((MW'(1) << CE_BIT) | (MW'(1) << DE_BIT));

    logic [MW-1:0] msr_d;

    // Next-state selection: entry, then return, then software write.
    always_comb begin
        msr_d = msr_o;
        unique case (ev_i)
            EV_CRIT, EV_WDT: msr_d = msr_o & CLR_MASK;
            EV_RET:          msr_d = save_msr_i;
            default:         if (wr_en_i) msr_d = wr_data_i;
        endcase
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) msr_o <= '0;
        else        msr_o <= msr_d;
    end
endmodule

// File: rtl/crit_entry_ctrl.sv
// Module: top of the critical interrupt entry controller.
// Assumes: all outputs are registered, so results appear one edge after the
// inputs that caused them; redirect_pc_o holds between redirects.
module crit_entry_ctrl
    import crit_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          MW       = 32,
    parameter int          CE_BIT   = 14,
    parameter int          DE_BIT   = 9,
    parameter logic [15:0] CRIT_OFS = 16'h0100,
    parameter logic [15:0] WDT_OFS  = 16'h0200,
    localparam int         PW       = AW - 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crit_req_i,
    input  logic          wdt_req_i,
    input  logic          sync_exc_pend_i,
    input  logic [AW-1:0] pc_next_i,
    input  logic [PW-1:0] vec_prefix_i,
    input  logic          msr_wr_en_i,
    input  logic [MW-1:0] msr_wr_data_i,
    input  logic          rfci_i,
    output logic          take_o,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o,
    output logic [MW-1:0] msr_o,
    output logic [AW-1:0] save_pc_o,
    output logic [MW-1:0] save_msr_o
);
    crit_ev_e      ev;
    logic [AW-1:0] target;
    logic          entry;

    crit_arbiter #(
        .AW(AW), .CRIT_OFS(CRIT_OFS), .WDT_OFS(WDT_OFS)
    ) i_arb (
        .crit_req_i      (crit_req_i),
        .wdt_req_i       (wdt_req_i),
        .sync_exc_pend_i (sync_exc_pend_i),
        .ce_i            (msr_o[CE_BIT]),
        .rfci_i          (rfci_i),
        .vec_prefix_i    (vec_prefix_i),
        .save_pc_i       (save_pc_o),
        .ev_o            (ev),
        .target_o        (target)
    );

    // Flag the two entry events for the save registers and the pulse.
    always_comb entry = (ev == EV_CRIT) || (ev == EV_WDT);

    crit_save_regs #(.AW(AW), .MW(MW)) i_save (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (entry),
        .pc_i       (pc_next_i),
        .msr_i      (msr_o),
        .save_pc_o  (save_pc_o),
        .save_msr_o (save_msr_o)
    );

    crit_msr_reg #(.MW(MW), .CE_BIT(CE_BIT), .DE_BIT(DE_BIT)) i_msr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .wr_en_i    (msr_wr_en_i),
        .wr_data_i  (msr_wr_data_i),
        .save_msr_i (save_msr_o),
        .msr_o      (msr_o)
    );

    // Register the take and redirect pulses and hold the target between redirects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o        <= 1'b0;
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
        end else begin
            take_o     <= entry;
            redirect_o <= (ev != EV_NONE);
            if (ev != EV_NONE) redirect_pc_o <= target;
        end
    end
endmodule

// File: rtl/crit_entry_chk.sv
// Module: property checker attached to every crit_entry_ctrl instance.
// Assumes: observes ports only; reset is synchronous and active low.
module crit_entry_chk #(
    parameter int AW     = 32,
    parameter int MW     = 32,
    parameter int CE_BIT = 14,
    parameter int DE_BIT = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_exc_pend_i,
    input logic [AW-1:0] pc_next_i,
    input logic          take_o,
    input logic          redirect_o,
    input logic [AW-1:0] redirect_pc_o,
    input logic [MW-1:0] msr_o,
    input logic [AW-1:0] save_pc_o,
    input logic [MW-1:0] save_msr_o
);
    // R2: every entry is also a redirect.
    p_take_redirects_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> redirect_o);

    // R3: entry only from a state with the enable set.
    p_take_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(msr_o[CE_BIT]));

    // R5: no entry while a precise exception was outstanding.
    p_sync_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(sync_exc_pend_i));

    // R6: the save pair captures the pre-entry address and state.
    p_save_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (save_pc_o == $past(pc_next_i)) && (save_msr_o == $past(msr_o)));

    // R7: both enables are cleared after entry.
    p_enables_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !msr_o[CE_BIT] && !msr_o[DE_BIT]);

    // R10: a return restores the state and jumps to the saved address.
    p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && !take_o) |-> (msr_o == $past(save_msr_o))
                                    && (redirect_pc_o == $past(save_pc_o)));

    // R11: the take pulse lasts one cycle.
    p_take_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R11: the target is stable when no redirect occurs.
    p_target_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> $stable(redirect_pc_o));
endmodule

bind crit_entry_ctrl crit_entry_chk #(
    .AW(AW), .MW(MW), .CE_BIT(CE_BIT), .DE_BIT(DE_BIT)
) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sync_exc_pend_i (sync_exc_pend_i),
    .pc_next_i       (pc_next_i),
    .take_o          (take_o),
    .redirect_o      (redirect_o),
    .redirect_pc_o   (redirect_pc_o),
    .msr_o           (msr_o),
    .save_pc_o       (save_pc_o),
    .save_msr_o      (save_msr_o)
);

// File: tb/test_crit_entry_ctrl.sv
// Bench: behavioural reference model stepped every clock and compared to the DUT.
module test_crit_entry_ctrl;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW = 32;
    localparam int          MW = 32;
    localparam int          CE = 14;
    localparam int          DE = 9;
    localparam logic [15:0] CRIT_VEC = 16'h0100;
    localparam logic [15:0] WDT_VEC  = 16'h0200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          crit_req = 1'b0, wdt_req = 1'b0, sync_pend = 1'b0;
    logic [AW-1:0] pc_next = 32'h0000_1000;
    logic [15:0]   prefix = 16'hFFF0;
    logic          msr_we = 1'b0;
    logic [MW-1:0] msr_wd = '0;
    logic          rfci = 1'b0;

    logic          take, redir;
    logic [AW-1:0] rpc, spc;
    logic [MW-1:0] msr, smsr;

    // Reference state.
    logic          m_take, m_redir;
    logic [AW-1:0] m_rpc, m_spc;
    logic [MW-1:0] m_msr, m_smsr;

    int vectors = 0;
    int misses  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crit_entry_ctrl i_crit_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .crit_req_i(crit_req), .wdt_req_i(wdt_req),
        .sync_exc_pend_i(sync_pend), .pc_next_i(pc_next), .vec_prefix_i(prefix),
        .msr_wr_en_i(msr_we), .msr_wr_data_i(msr_wd), .rfci_i(rfci),
        .take_o(take), .redirect_o(redir), .redirect_pc_o(rpc),
        .msr_o(msr), .save_pc_o(spc), .save_msr_o(smsr)
    );

    task automatic model_edge();
        logic ok;
        ok = m_msr[CE] && !sync_pend;
        if (!rst_n) begin
            m_take = 0; m_redir = 0; m_rpc = '0; m_spc = '0; m_smsr = '0; m_msr = '0;
        end else if (ok && (crit_req || wdt_req)) begin
            m_spc   = pc_next;
            m_smsr  = m_msr;
            m_msr[CE] = 1'b0;
            m_msr[DE] = 1'b0;
            m_take  = 1; m_redir = 1;
            m_rpc   = {prefix, crit_req ? CRIT_VEC : WDT_VEC};
        end else if (rfci) begin
            m_msr = m_smsr; m_take = 0; m_redir = 1; m_rpc = m_spc;
        end else begin
            if (msr_we) m_msr = msr_wd;
            m_take = 0; m_redir = 0;
        end
    endtask

    task automatic cmp(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One clock: inputs are already set; model advances at the edge, outputs compared after.
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp(req, "take_o", 64'(take), 64'(m_take));
        cmp(req, "redirect_o", 64'(redir), 64'(m_redir));
        cmp(req, "redirect_pc_o", 64'(rpc), 64'(m_rpc));
        cmp(req, "msr_o", 64'(msr), 64'(m_msr));
        cmp(req, "save_pc_o", 64'(spc), 64'(m_spc));
        cmp(req, "save_msr_o", 64'(smsr), 64'(m_smsr));
        pc_next = pc_next + 4;
        msr_we = 0; rfci = 0;
    endtask

    initial begin
        logic [MW-1:0] armed;
        armed = 32'h1234_0005 | (32'h1 << CE) | (32'h1 << DE);
        @(negedge clk);
        step("R1"); step("R1");
        cmp("R1", "reset msr_o", 64'(msr), 64'h0);
        rst_n = 1;
        // R3: request ignored while enable is clear.
        crit_req = 1;
        step("R3"); step("R3"); step("R3");
        cmp("R3", "no take while disabled", 64'(take), 64'h0);
        // R4: software write re-arms; request still held.
        msr_we = 1; msr_wd = armed;
        step("R4");
        cmp("R4", "msr_o after write", 64'(msr), 64'(armed));
        // R2, R6, R7: entry via request line.
        step("R2");
        cmp("R2", "entry vector", 64'(rpc), 64'({prefix, CRIT_VEC}));
        cmp("R7", "other bits kept", 64'(msr), 64'(armed & ~((32'h1 << CE) | (32'h1 << DE))));
        cmp("R6", "saved msr", 64'(smsr), 64'(armed));
        // R11: held request gives no second entry.
        step("R11"); step("R11"); step("R11");
        cmp("R11", "single pulse", 64'(take), 64'h0);
        // R10: return restores and re-enables; held request then re-enters.
        rfci = 1;
        step("R10");
        cmp("R10", "restored msr", 64'(msr), 64'(armed));
        step("R2");
        crit_req = 0;
        rfci = 1; step("R10");
        // R5: watchdog held back by sync pending.
        wdt_req = 1; sync_pend = 1;
        step("R5"); step("R5"); step("R5");
        cmp("R5", "held by sync", 64'(take), 64'h0);
        sync_pend = 0; prefix = 16'h00A5;
        step("R8");
        cmp("R8", "watchdog vector", 64'(rpc), 64'({16'h00A5, WDT_VEC}));
        wdt_req = 0;
        rfci = 1; step("R10");
        // R9: both sources together.
        crit_req = 1; wdt_req = 1;
        step("R9");
        cmp("R9", "line wins", 64'(rpc), 64'({16'h00A5, CRIT_VEC}));
        crit_req = 0; wdt_req = 0;
        // R12: return beats a software write.
        rfci = 1; msr_we = 1; msr_wd = 32'h0000_0001;
        step("R12");
        cmp("R12", "write lost to return", 64'(msr), 64'(armed));
        // R12: entry beats return and write.
        crit_req = 1; rfci = 1; msr_we = 1; msr_wd = 32'hFFFF_FFFF;
        step("R12");
        cmp("R12", "entry wins", 64'(take), 64'h1);
        crit_req = 0;
        step("R11");
        msr_we = 1; msr_wd = '0;
        step("R4");
        step("R3");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule